// File: doc/BRIEF.md
# Burst column address sequencer

This block produces the column address of every beat of a memory burst. A controller presents a starting column, a burst-length code, an ordering select (wrap-around increment or XOR interleave), a write-single select and a read/write marker, then pulses `start`. The block captures that configuration and emits one column address per accepted beat on a valid/ready stream, flagging the final beat. Only the low column bits inside the aligned burst block move. The bits above the block stay as given.

The address stream follows valid/ready rules. `out_valid` rises the cycle after a burst is accepted and stays high until the burst ends. A beat is consumed only on a clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, the address and last flag hold steady. The consumer may hold `out_ready` low for any number of cycles. A full-page burst walks every column in increment order with wrap-around and runs until `term` is sampled high. `term` also cuts a shorter burst short.

Burst-length codes: 0 = one beat, 1 = two, 2 = four, 3 = eight, 7 = full page, 4/5/6 = reserved. `ilv` = 0 selects increment ordering and 1 selects interleave.

Top module: `burst_col_seq`

## Requirements
- R1: When idle, a `start` with a legal configuration is accepted on that clock edge. On the next cycle `busy` and `out_valid` are high and `out_col` equals the starting column.
- R2: With `ilv`=0 and code 0/1/2/3 (length L = 1/2/4/8), beat k carries low bits (start+k) mod L inside the aligned block of L columns. The bits above the block equal the starting column.
- R3: With `ilv`=1 and code 1/2/3, beat k carries low bits equal to the starting low bits XOR k. The bits above the block equal the starting column.
- R4: Code 7 with `ilv`=0 produces start+k modulo the column space on beat k, wraps from the top column to 0, and never raises `out_last`.
- R5: When `term` is high at a clock edge during a burst, `out_valid` and `busy` are low from the next cycle.
- R6: `out_last` is high exactly on the final beat of a burst that is not full page. After that beat is accepted, `out_valid` is low.
- R7: With `wr_single`=1, a write (`start_wr`=1) is one beat at the starting column for every legal code. Reads keep their programmed length. With `wr_single`=0, writes use the programmed length.
- R8: A `start` with code 4, 5 or 6 is not accepted: `out_valid` and `busy` stay low, and `err_len_rsvd` is high for exactly the following cycle.
- R9: A `start` with code 7 and `ilv`=1 is not accepted: `out_valid` and `busy` stay low, and `err_ilv_page` is high for exactly the following cycle.
- R10: While `out_valid` is high and `out_ready` is low, `out_col` and `out_last` hold. A beat advances only on a valid-and-ready edge.
- R11: `start` while busy is ignored. The configuration inputs are captured when a burst is accepted, and later changes to them do not alter the running burst.
- R12: After reset, `busy`, `out_valid`, `out_last` and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Burst request strobe |
| start_wr | input | 1 | Request is a write (1) or a read (0) |
| start_col | input | COL_W | Starting column address |
| bl_code | input | 3 | Burst-length code |
| ilv | input | 1 | 0 = increment ordering, 1 = interleave ordering |
| wr_single | input | 1 | 1 = writes are single-beat |
| term | input | 1 | Stop the running burst |
| busy | output | 1 | Burst in progress |
| out_valid | output | 1 | Column address valid |
| out_ready | input | 1 | Consumer accepts the beat |
| out_col | output | COL_W | Column address of the current beat |
| out_last | output | 1 | Final beat of a bounded burst |
| err_len_rsvd | output | 1 | One-cycle pulse: reserved length code rejected |
| err_ilv_page | output | 1 | One-cycle pulse: interleave with full page rejected |

## Verification
The bench builds the block with `COL_W` = 6, so the column space has 64 locations. This makes every starting column reachable for every bounded length and both orderings in one short run. A full-page burst can also be driven past its wrap point and back to its start within a few dozen beats. A pseudo-random `out_ready` pattern applies back-pressure across the sweep.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int BL_CODE_W = 3;

  typedef enum logic [BL_CODE_W-1:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_RSV4  = 3'd4,
    BL_RSV5  = 3'd5,
    BL_RSV6  = 3'd6,
    BL_PAGE  = 3'd7
  } bl_code_e;

  typedef enum logic {
    ORD_INCR = 1'b0,
    ORD_XOR  = 1'b1
  } order_e;
endpackage

// File: rtl/bcs_cfg_decode.sv
module bcs_cfg_decode
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [BL_CODE_W-1:0] code,
  input  logic                 ilv,
  input  logic                 is_wr,
  input  logic                 wr_single,
  output logic [COL_W-1:0]     mask,
  output logic                 page,
  output logic                 rsvd,
  output logic                 bad_combo
);
  logic [1:0] lg;
  logic       single;

  always_comb begin
    lg   = 2'd0;
    page = 1'b0;
    rsvd = 1'b0;
    unique case (bl_code_e'(code))
      BL_ONE:   lg = 2'd0;
      BL_TWO:   lg = 2'd1;
      BL_FOUR:  lg = 2'd2;
      BL_EIGHT: lg = 2'd3;
      BL_PAGE:  page = 1'b1;
      default:  rsvd = 1'b1;
    endcase
    bad_combo = page && (order_e'(ilv) == ORD_XOR);
    single    = is_wr && wr_single;
    if (single) begin
      mask = '0;
      page = 1'b0;
    end else if (page) begin
      mask = '1;
    end else begin
      mask = ~({COL_W{1'b1}} << lg);
    end
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] idx,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] low_incr;
  logic [COL_W-1:0] low_xor;
  logic [COL_W-1:0] low_sel;

  always_comb begin
    low_incr = base + idx;
    low_xor  = base ^ idx;
    low_sel  = (order_e'(ilv) == ORD_XOR) ? low_xor : low_incr;
    col      = (base & ~mask) | (low_sel & mask);
  end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [COL_W-1:0] last_idx_in,
  input  logic             page_in,
  input  logic             term,
  input  logic             ready,
  output logic             active,
  output logic [COL_W-1:0] idx,
  output logic             last
);
  logic [COL_W-1:0] last_idx_q;
  logic             page_q;
  logic             fire;

  assign fire = active && ready;
  assign last = active && !page_q && (idx == last_idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active     <= 1'b0;
      idx        <= '0;
      last_idx_q <= '0;
      page_q     <= 1'b0;
    end else if (!active) begin
      if (launch) begin
        active     <= 1'b1;
        idx        <= '0;
        last_idx_q <= last_idx_in;
        page_q     <= page_in;
      end
    end else if (term) begin
      active <= 1'b0;
    end else if (fire) begin
      if (last) active <= 1'b0;
      else      idx    <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_wr,
  input  logic [COL_W-1:0]     start_col,
  input  logic [BL_CODE_W-1:0] bl_code,
  input  logic                 ilv,
  input  logic                 wr_single,
  input  logic                 term,
  output logic                 busy,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [COL_W-1:0]     out_col,
  output logic                 out_last,
  output logic                 err_len_rsvd,
  output logic                 err_ilv_page
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_page, dec_rsvd, dec_bad;
  logic             req, launch;
  logic [COL_W-1:0] base_q, mask_q, idx;
  logic             ilv_q, active;

  bcs_cfg_decode #(.COL_W(COL_W)) u_dec (
    .code(bl_code), .ilv(ilv), .is_wr(start_wr), .wr_single(wr_single),
    .mask(dec_mask), .page(dec_page), .rsvd(dec_rsvd), .bad_combo(dec_bad)
  );

  assign req    = start && !active;
  assign launch = req && !dec_rsvd && !dec_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q       <= '0;
      mask_q       <= '0;
      ilv_q        <= 1'b0;
      err_len_rsvd <= 1'b0;
      err_ilv_page <= 1'b0;
    end else begin
      err_len_rsvd <= req && dec_rsvd;
      err_ilv_page <= req && dec_bad;
      if (launch) begin
        base_q <= start_col;
        mask_q <= dec_mask;
        ilv_q  <= ilv;
      end
    end
  end

  bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .launch(launch), .last_idx_in(dec_mask),
    .page_in(dec_page), .term(term), .ready(out_ready),
    .active(active), .idx(idx), .last(out_last)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_addr (
    .base(base_q), .idx(idx), .mask(mask_q), .ilv(ilv_q), .col(out_col)
  );

  assign busy      = active;
  assign out_valid = active;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             term,
  input logic             busy,
  input logic             out_valid,
  input logic             out_ready,
  input logic [COL_W-1:0] out_col,
  input logic             out_last,
  input logic             err_len_rsvd,
  input logic             err_ilv_page
);
  a_r5_term_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && term) |=> !out_valid);

  a_r6_last_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);

  a_r6_last_has_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !term) |=> (out_valid && $stable(out_col) && $stable(out_last)));

  a_r8_rsvd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_len_rsvd |-> (!out_valid && !busy));

  a_r9_page_idle: assert property (@(posedge clk) disable iff (!rst_n)
    err_ilv_page |-> (!out_valid && !busy));

  a_r8_err_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_len_rsvd, err_ilv_page}));

  a_r11_no_err_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(err_len_rsvd || err_ilv_page));
endmodule

bind burst_col_seq bcs_checker #(.COL_W(COL_W)) u_bcs_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .term(term), .busy(busy),
  .out_valid(out_valid), .out_ready(out_ready), .out_col(out_col),
  .out_last(out_last), .err_len_rsvd(err_len_rsvd), .err_ilv_page(err_ilv_page)
);

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 6;
  localparam int NCOL = 1 << COL_W;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, start_wr = 1'b0, ilv = 1'b0, wr_single = 1'b0, term = 1'b0;
  logic [COL_W-1:0] start_col = '0;
  logic [2:0] bl_code = 3'd0;
  logic out_ready = 1'b0;
  logic busy, out_valid, out_last, err_len_rsvd, err_ilv_page;
  logic [COL_W-1:0] out_col;
  logic [7:0] lfsr = 8'h5a;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  burst_col_seq #(.COL_W(COL_W)) i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
    .start_col(start_col), .bl_code(bl_code), .ilv(ilv), .wr_single(wr_single),
    .term(term), .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
    .out_col(out_col), .out_last(out_last), .err_len_rsvd(err_len_rsvd),
    .err_ilv_page(err_ilv_page)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_col(input int s, input int len, input bit x, input int k);
    int m;
    m = len - 1;
    if (x) return (s & ~m & (NCOL-1)) | ((s ^ k) & m);
    return (s & ~m & (NCOL-1)) | ((s + k) & m);
  endfunction

  task automatic step_lfsr();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
  endtask

  // Bounded burst; checks R1, R2/R3, R6, R7, R10, R11
  task automatic run_burst(input int s, input int code, input bit x, input bit wr,
                           input bit wsing, input bit poke);
    int len, k, stall_col;
    len = (wr && wsing) ? 1 : (1 << code);
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(s); bl_code = 3'(code); ilv = x;
    start_wr = wr; wr_single = wsing;
    @(negedge clk);
    start = 1'b0;
    // R11: scramble configuration after acceptance
    start_col = ~COL_W'(s); bl_code = 3'd3; ilv = ~x; start_wr = ~wr; wr_single = ~wsing;
    check(out_valid && busy, "R1 valid after accept", int'(out_valid), 1);
    check(int'(out_col) == s, "R1 first column", int'(out_col), s);
    k = 0;
    stall_col = -1;
    while (k < len && !done) begin
      if (!out_valid) begin
        check(1'b0, "R6 valid dropped early", 0, 1);
        break;
      end
      if (stall_col >= 0)
        check(int'(out_col) == stall_col, "R10 hold while stalled", int'(out_col), stall_col);
      if (poke && k == 1) begin
        start = 1'b1; start_col = COL_W'(s + 7); bl_code = 3'd7; ilv = 1'b1;
      end
      out_ready = lfsr[0] | lfsr[1];
      if (out_ready) begin
        check(int'(out_col) == exp_col(s, len, x, k),
              x ? "R3 interleave column" : (wr && wsing) ? "R7 single write" : "R2 increment column",
              int'(out_col), exp_col(s, len, x, k));
        check(out_last == (k == len - 1), "R6 last flag", int'(out_last), int'(k == len - 1));
        k++;
        stall_col = -1;
      end else begin
        stall_col = int'(out_col);
      end
      @(negedge clk);
      start = 1'b0;
      step_lfsr();
    end
    out_ready = 1'b0;
    check(!out_valid && !busy, "R6 idle after last", int'(out_valid), 0);
    check(!err_len_rsvd && !err_ilv_page, "R11 no error from ignored start", int'(err_ilv_page), 0);
  endtask

  // Full page; R4, R5
  task automatic run_page(input int s, input int beats);
    @(negedge clk);
    start = 1'b1; start_col = COL_W'(s); bl_code = 3'd7; ilv = 1'b0; start_wr = 1'b0;
    @(negedge clk);
    start = 1'b0;
    out_ready = 1'b1;
    for (int k = 0; k < beats; k++) begin
      check(out_valid && int'(out_col) == ((s + k) % NCOL), "R4 page column",
            int'(out_col), (s + k) % NCOL);
      check(!out_last, "R4 page no last", int'(out_last), 0);
      @(negedge clk);
    end
    term = 1'b1;
    @(negedge clk);
    term = 1'b0; out_ready = 1'b0;
    check(!out_valid && !busy, "R5 terminate page", int'(out_valid), 0);
  endtask

  task automatic reject(input int code, input bit x, input bit rsv);
    @(negedge clk);
    start = 1'b1; start_col = 6'd9; bl_code = 3'(code); ilv = x; start_wr = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (rsv) check(err_len_rsvd && !out_valid && !busy, "R8 reserved code", int'(err_len_rsvd), 1);
    else     check(err_ilv_page && !out_valid && !busy, "R9 interleave page", int'(err_ilv_page), 1);
    @(negedge clk);
    check(!err_len_rsvd && !err_ilv_page && !out_valid, "R8 R9 pulse one cycle",
          int'(err_len_rsvd | err_ilv_page), 0);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !out_valid && !out_last && !err_len_rsvd && !err_ilv_page,
          "R12 reset state", int'(busy | out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R2, R3: all starts, all bounded lengths, both orderings, reads
    for (int code = 0; code < 4; code++)
      for (int x = 0; x < 2; x++)
        for (int s = 0; s < NCOL; s++)
          run_burst(s, code, x[0], 1'b0, 1'b1, (s % 13) == 4);
    // R7: writes single vs programmed length
    for (int code = 0; code < 4; code++)
      for (int s = 0; s < NCOL; s += 5) begin
        run_burst(s, code, 1'b0, 1'b1, 1'b1, 1'b0);
        run_burst(s, code, 1'b1, 1'b1, 1'b0, 1'b0);
      end
    // R7: single write with full-page code
    @(negedge clk);
    start = 1'b1; start_col = 6'd33; bl_code = 3'd7; ilv = 1'b0; start_wr = 1'b1; wr_single = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(out_valid && out_col == 6'd33 && out_last, "R7 single write page code", int'(out_col), 33);
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid, "R7 single write ends", int'(out_valid), 0);
    wr_single = 1'b0;
    // R4, R5
    run_page(0, NCOL + 3);
    run_page(61, NCOL + 10);
    // R5 on a bounded burst
    @(negedge clk);
    start = 1'b1; start_col = 6'd21; bl_code = 3'd3; ilv = 1'b0; start_wr = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(out_col == 6'd23, "R2 third beat", int'(out_col), 23);
    term = 1'b1;
    @(negedge clk);
    term = 1'b0; out_ready = 1'b0;
    check(!out_valid && !busy, "R5 terminate burst", int'(out_valid), 0);
    // R8, R9
    reject(4, 1'b0, 1'b1);
    reject(5, 1'b1, 1'b1);
    reject(6, 1'b0, 1'b1);
    reject(7, 1'b1, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule